// File: doc/BRIEF.md
# Configuration Stream Header Stripper

This block sits on a byte stream that carries one configuration file after another. It throws away the file's leading header and hands on only the configuration payload, starting at the sync preamble. The header is a fixed run of lead-in bytes, followed by a chain of length-prefixed text fields. After the last field there may be some filler, and then the preamble: four consecutive 0xFF bytes.

Both sides use valid/ready byte handshakes with an end-of-file flag. While the block is walking the header and searching for the preamble, it accepts every input byte without looking at the output side. Once the preamble is found, the held 0xFF bytes are replayed downstream, and from then on bytes pass straight through until the end of the file.

The block also reports the file offset of the payload start, or a no-sync error when the file ends without a preamble. When a file ends, the block starts again at offset 0 for the next file.

Top module: `cfg_payload_extract`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, sync_err is 0 and offset_vld is 0.
- R2: Bytes at file offsets 0 to 14 are discarded whatever their value, including 0xFF. The byte at offset 15 is the length byte of the first header field.
- R3: There are four header fields. When the length byte at offset P holds value L, the next length byte is at offset P+L+3. Every byte between two length bytes is discarded, including runs of 0xFF.
- R4: The preamble search starts at offset P+L+3 of the fourth field. It looks for four consecutive 0xFF bytes. Any other byte value restarts the count, so a run of three 0xFF followed by a different byte is not a match.
- R5: The output carries the four preamble bytes (0xFF) first, then every following input byte in order. out_last is 1 on the final byte of the file and on no other byte.
- R6: On a match, payload_offset holds the file offset of the first preamble byte and offset_vld is 1. Both keep their values until the first byte of the next file is accepted.
- R7: If the end-of-file byte is accepted before a match, sync_err becomes 1, offset_vld stays 0, and no byte is output for that file.
- R8: Until the fourth preamble byte has been accepted, in_ready is 1 whatever the value of out_ready.
- R9: After a file ends, whether with a match or with an error, the next input byte is treated as offset 0 of a new file.
- R10: While the held preamble bytes are being replayed, in_ready is 0. Each held byte stays on the output until out_ready takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last byte of the file |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last byte of the file |
| sync_err | output | 1 | The file ended without a preamble |
| offset_vld | output | 1 | payload_offset holds the start of the current payload |
| payload_offset | output | 16 | File offset of the first preamble byte |

## Verification
Header and search bytes are taken in the same cycle they are offered. The first replayed 0xFF appears one cycle after the handshake of the fourth preamble byte, and pass-through bytes reach the output in the same cycle with no added register. sync_err, offset_vld and payload_offset change one clock after the deciding handshake (the fourth 0xFF, or the end-of-file byte). The bench therefore drives all inputs just after the falling edge and samples one nanosecond later. It counts a transfer only when valid and ready are both high at that sample. It reads the status outputs only after the last transfer of a file has been followed by at least one more clock edge.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_PASS  = 2'd2
  } xtr_state_e;

  // offset of the next length byte, from the current one and its value
  function automatic int next_len_pos(input int cur, input logic [7:0] len, input int gap);
    return cur + int'(len) + gap;
  endfunction

  function automatic logic is_sync_byte(input logic [7:0] b);
    return b == SYNC_BYTE;
  endfunction

endpackage

// File: rtl/cfg_hdr_walk.sv
module cfg_hdr_walk
  import cfg_hdr_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int PREFIX_LEN = 15,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic [7:0]       data,
  output logic [POS_W-1:0] pos,
  output logic             in_window
);

  localparam int FCW = $clog2(NUM_FIELDS + 1);

  logic [POS_W-1:0] target_q;
  logic [FCW-1:0]   fld_cnt_q;
  logic             hdr_done;
  logic             len_hit;

  assign hdr_done  = (fld_cnt_q == FCW'(NUM_FIELDS));
  assign len_hit   = take && !hdr_done && (pos == target_q);
  assign in_window = hdr_done && (pos >= target_q);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pos       <= '0;
      target_q  <= POS_W'(PREFIX_LEN);
      fld_cnt_q <= '0;
    end else if (take) begin
      pos <= pos + 1'b1;
      if (len_hit) begin
        target_q  <= POS_W'(next_len_pos(32'(pos), data, FIELD_GAP));
        fld_cnt_q <= fld_cnt_q + 1'b1;
      end
    end
  end

  // R2
  prefix_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (pos < POS_W'(PREFIX_LEN))) |-> !len_hit);

  // R3
  fld_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_cnt_q <= FCW'(NUM_FIELDS));

endmodule

// File: rtl/cfg_sync_find.sv
module cfg_sync_find
  import cfg_hdr_pkg::*;
#(
  parameter int SYNC_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       take,
  input  logic [7:0] data,
  output logic       hit
);

  localparam int RUN_W = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;

  logic [RUN_W-1:0] run_q;
  logic             is_ff;

  assign is_ff = is_sync_byte(data);
  assign hit   = take && is_ff && (run_q == RUN_W'(SYNC_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      run_q <= '0;
    end else if (take) begin
      if (!is_ff || hit) run_q <= '0;
      else               run_q <= run_q + 1'b1;
    end
  end

  // R4
  run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_ff) |=> (run_q == '0));

endmodule

// File: rtl/cfg_payload_extract.sv
module cfg_payload_extract
  import cfg_hdr_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int PREFIX_LEN = 15,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_GAP  = 3,
  parameter int SYNC_LEN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             sync_err,
  output logic             offset_vld,
  output logic [POS_W-1:0] payload_offset
);

  localparam int FLW = $clog2(SYNC_LEN + 1);

  xtr_state_e       state_q;
  logic [FLW-1:0]   flush_cnt_q;
  logic             flush_last_q;

  logic             scan_take;
  logic             sync_take;
  logic             in_window;
  logic             hit;
  logic [POS_W-1:0] pos;
  logic             flush_fire;
  logic             flush_end;
  logic             pass_end;
  logic             restart;

  assign scan_take  = (state_q == ST_SCAN) && in_valid;
  assign sync_take  = scan_take && in_window;
  assign flush_fire = (state_q == ST_FLUSH) && out_ready;
  assign flush_end  = flush_fire && (flush_cnt_q == FLW'(1));
  assign pass_end   = (state_q == ST_PASS) && in_valid && out_ready && in_last;
  assign restart    = (scan_take && in_last && !hit) || (flush_end && flush_last_q) || pass_end;

  cfg_hdr_walk #(
    .POS_W(POS_W), .PREFIX_LEN(PREFIX_LEN), .NUM_FIELDS(NUM_FIELDS), .FIELD_GAP(FIELD_GAP)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .take(scan_take),
    .data(in_data), .pos(pos), .in_window(in_window)
  );

  cfg_sync_find #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .restart(restart), .take(sync_take),
    .data(in_data), .hit(hit)
  );

  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    unique case (state_q)
      ST_FLUSH: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = SYNC_BYTE;
        out_last  = flush_last_q && (flush_cnt_q == FLW'(1));
      end
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_SCAN;
      flush_cnt_q    <= '0;
      flush_last_q   <= 1'b0;
      sync_err       <= 1'b0;
      offset_vld     <= 1'b0;
      payload_offset <= '0;
    end else begin
      unique case (state_q)
        ST_SCAN: if (scan_take) begin
          if (pos == '0) begin
            sync_err   <= 1'b0;
            offset_vld <= 1'b0;
          end
          if (hit) begin
            state_q        <= ST_FLUSH;
            flush_cnt_q    <= FLW'(SYNC_LEN);
            flush_last_q   <= in_last;
            payload_offset <= pos - POS_W'(SYNC_LEN - 1);
            offset_vld     <= 1'b1;
          end else if (in_last) begin
            sync_err <= 1'b1;
          end
        end
        ST_FLUSH: if (flush_fire) begin
          flush_cnt_q <= flush_cnt_q - 1'b1;
          if (flush_end) state_q <= flush_last_q ? ST_SCAN : ST_PASS;
        end
        ST_PASS: if (pass_end) state_q <= ST_SCAN;
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  // R6
  offset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(offset_vld) |-> (out_valid && out_data == SYNC_BYTE));

  // R7
  no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !offset_vld);

  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && !out_ready) |=> (out_valid && !in_ready && out_data == SYNC_BYTE));

  // R5
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: tb/test_cfg_payload_extract.sv
module test_cfg_payload_extract;

  typedef struct packed {
    logic [7:0] l0, l1, l2, l3;
    logic [1:0] junk;
    logic [7:0] pay;
    logic [1:0] rdy;
    logic       sync;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 8'd0, 8'd5, 8'd1, 2'd0, 8'd10, 2'd0, 1'b1},
    '{8'd0, 8'd0, 8'd0, 8'd0, 2'd1, 8'd6,  2'd1, 1'b1},
    '{8'd7, 8'd3, 8'd1, 8'd9, 2'd3, 8'd12, 2'd2, 1'b1},
    '{8'd4, 8'd4, 8'd4, 8'd4, 2'd2, 8'd8,  2'd0, 1'b0},
    '{8'd1, 8'd2, 8'd3, 8'd4, 2'd1, 8'd1,  2'd3, 1'b1},
    '{8'd3, 8'd0, 8'd2, 8'd0, 2'd0, 8'd0,  2'd3, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        sync_err;
  logic        offset_vld;
  logic [15:0] payload_offset;

  always #10 clk = ~clk;

  cfg_payload_extract i_cfg_payload_extract (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .sync_err(sync_err), .offset_vld(offset_vld), .payload_offset(payload_offset)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [512];
  int flen;
  logic [7:0] cap [512];
  logic cap_last [512];
  int cap_n, ir_fail, fl_fail, exp_start;

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic put(inout int p, input logic [7:0] b);
    mem[p] = b;
    p++;
  endtask

  task automatic build(input vec_t v);
    int p = 0;
    logic [7:0] ls [4];
    ls = '{v.l0, v.l1, v.l2, v.l3};
    for (int i = 0; i < 15; i++) put(p, 8'hFF);
    for (int f = 0; f < 4; f++) begin
      put(p, ls[f]);
      for (int k = 0; k < int'(ls[f]) + 2; k++) put(p, 8'hFF);
    end
    case (v.junk)
      2'd1: begin put(p, 8'hFF); put(p, 8'hFF); put(p, 8'hFF); put(p, 8'h00); end
      2'd2: begin put(p, 8'h00); put(p, 8'h11); put(p, 8'hFF); put(p, 8'hA5); end
      2'd3: begin
        put(p, 8'hFF); put(p, 8'hFF); put(p, 8'h00);
        put(p, 8'hFF); put(p, 8'hFF); put(p, 8'hFF); put(p, 8'h7E);
      end
      default: ;
    endcase
    if (v.sync) for (int k = 0; k < 4; k++) put(p, 8'hFF);
    for (int k = 0; k < int'(v.pay); k++) put(p, (k == 1) ? 8'hFF : 8'((k * 37 + 3) & 8'hFE));
    flen = p;
  endtask

  // independent restatement of the header walk and preamble search
  function automatic int ref_start();
    int idx = 15;
    for (int f = 0; f < 4; f++) idx = idx + int'(mem[idx]) + 3;
    for (int j = idx; j + 3 < flen; j++)
      if (mem[j] == 8'hFF && mem[j+1] == 8'hFF && mem[j+2] == 8'hFF && mem[j+3] == 8'hFF)
        return j;
    return -1;
  endfunction

  task automatic run_file(input logic [1:0] rdy);
    int idx = 0;
    int cyc = 0;
    int lim;
    cap_n = 0; ir_fail = 0; fl_fail = 0;
    lim = (exp_start < 0) ? flen : exp_start + 4;
    while (1) begin
      in_valid = (idx < flen);
      in_data  = (idx < flen) ? mem[idx] : 8'h00;
      in_last  = (idx == flen - 1);
      case (rdy)
        2'd1: out_ready = cyc[0];
        2'd2: out_ready = (cyc % 3 == 2);
        2'd3: out_ready = (cyc >= 60);
        default: out_ready = 1'b1;
      endcase
      #1;
      if (in_valid && idx < lim && !in_ready) ir_fail++;
      if (in_valid && exp_start >= 0 && idx == lim && cap_n < 4 && out_valid && in_ready) fl_fail++;
      if (out_valid && out_ready) begin
        cap[cap_n] = out_data;
        cap_last[cap_n] = out_last;
        cap_n++;
      end
      if (in_valid && in_ready) idx++;
      if (!in_valid && !out_valid) break;
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R5 file hang", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state, with out_ready held low
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);
    check(!sync_err && !offset_vld, "R1 status", int'({sync_err, offset_vld}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      int expn, bad, lastbad;
      build(VECS[v]);
      exp_start = ref_start();
      run_file(VECS[v].rdy);
      expn = (exp_start < 0) ? 0 : flen - exp_start;
      // R7 error flag; the vector after the error one also covers R9
      check(sync_err == (exp_start < 0), "R7 R9 sync_err", int'(sync_err), int'(exp_start < 0));
      check(offset_vld == (exp_start >= 0), "R6 offset_vld", int'(offset_vld), int'(exp_start >= 0));
      if (exp_start >= 0)
        check(int'(payload_offset) == exp_start, "R6 R9 payload_offset", int'(payload_offset), exp_start);
      check(cap_n == expn, "R5 R7 output count", cap_n, expn);
      bad = 0; lastbad = 0;
      for (int k = 0; k < cap_n && k < expn; k++) begin
        if (cap[k] != mem[exp_start + k]) bad++;
        if (cap_last[k] != (k == expn - 1)) lastbad++;
      end
      // R2 R3 R4 header skipping and preamble position decide these bytes
      check(bad == 0, "R2 R3 R4 R5 payload bytes", bad, 0);
      check(lastbad == 0, "R5 out_last placement", lastbad, 0);
      check(ir_fail == 0, "R8 in_ready during scan", ir_fail, 0);
      check(fl_fail == 0, "R10 in_ready during replay", fl_fail, 0);
    end

    // R9 reset-free restart: a truncated file with no preamble, then a good file
    for (int k = 0; k < 20; k++) mem[k] = 8'hFF;
    flen = 20;
    exp_start = -1;
    run_file(2'd0);
    check(sync_err, "R7 short file", int'(sync_err), 1);
    check(!offset_vld, "R7 short file offset_vld", int'(offset_vld), 0);
    build(VECS[0]);
    exp_start = ref_start();
    run_file(2'd0);
    check(!sync_err && offset_vld && int'(payload_offset) == exp_start,
          "R9 new file after error", int'(payload_offset), exp_start);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule